// File: doc/BRIEF.md
# PWM Configuration Shadow/Active Update Controller

This block keeps two copies of every PWM configuration field: the period, one compare value per channel, the channel action control, the pause bits, the breath period and the breath hold time. Bus writes land only in the shadow copy. The PWM datapath reads the active copy, which takes the shadow value only when the selected update policy allows. This means software can rewrite a field while a waveform runs, and no half-changed setting ever reaches the counter logic.

There are three update policies. In immediate mode, an active register follows its shadow. In per-register sync mode, each field loads on the event it belongs to: period end for the flicker fields and breath end for the breath fields. In sync-all mode, a write to the period (flicker) or to the breath period (breath) arms one grouped commit, and that commit happens at the next matching event. A rising edge of either enable forces an immediate load of the fields that mode uses.

Top module: `pwm_shadow_update`

## Requirements
- R1: While `rst_n` is low, and directly after reset, every shadow and active register is zero.
- R2: Bit i of `wr_en` and `sync_sep` selects a register in this order: 0 period, 1..NUM_CH compares, NUM_CH+1 action control, NUM_CH+2 pause, NUM_CH+3 breath period, NUM_CH+4 hold. A write changes only the shadow. Any load copies the shadow including a write in the same cycle, and the result is visible after that clock edge.
- R3: With `sync_all`=0 and a register's `sync_sep` bit at 0, that active register equals its shadow after every edge.
- R4: With per-register sync (`sync_all`=0, bit set), compares, action control and pause load only on `period_end` while flicker is enabled. Breath period and hold load only on `breath_end` while breath is enabled.
- R5: With per-register sync on the period, it loads on `period_end` while flicker is enabled and on `breath_end` while breath is enabled.
- R6: Under sync-all, a period write while flicker is enabled arms a commit. At a later `period_end` with flicker enabled, the period, all compares and the action control load together. With no commit armed, `period_end` loads nothing.
- R7: Under sync-all, a breath-period write while breath is enabled arms a commit. At a later `breath_end` with breath enabled, the period, breath period and hold load together.
- R8: Under sync-all, the active pause changes only on a flicker enable rising edge.
- R9: Flicker enable is `en` & ~`breath_sel`. In the cycle it rises, the period, compares, action control and pause load.
- R10: Breath enable is `en` & `breath_sel`. In the cycle it rises, the period, breath period and hold load.
- R11: When `sync_all` is 1, the `sync_sep` bits have no effect.
- R12: The armed commit clears when it commits and whenever `en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | NUM_CH+5 | Per-register shadow write strobes (order in R2) |
| wr_data | input | DATA_W | Write data, low bits used per register |
| sync_all | input | 1 | Select sync-all policy |
| sync_sep | input | NUM_CH+5 | Per-register sync select bits |
| en | input | 1 | Module enable |
| breath_sel | input | 1 | 1 selects breath operation, 0 flicker |
| period_end | input | 1 | Counter reached period minus one |
| breath_end | input | 1 | Breath cycle finished |
| act_prd | output | PRD_W | Active period |
| act_cmp | output | NUM_CH x CMP_W | Active compare values |
| act_ctl | output | ACT_W | Active action control |
| act_pause | output | PAUSE_W | Active pause bits |
| act_brp | output | BR_W | Active breath period |
| act_hold | output | BR_W | Active hold time |

## Verification
The assertions check on every cycle that an immediate-mode period write appears one edge later. They also check that a per-register compare, a sync-all pause and a sync-all breath period stay unchanged when none of their load events occurs, and that disabling drops the armed commit. Only the bench scenarios can show the grouped commit itself. That includes the arm-then-commit ordering, the clearing of the arm on disable as seen through a later `period_end`, the loads on enable edges, and the priority of sync-all over the per-register bits.

// File: rtl/pwm_upd_pkg.sv
package pwm_upd_pkg;

    typedef enum logic [1:0] {
        POL_IMM = 2'd0,
        POL_SEP = 2'd1,
        POL_ALL = 2'd2
    } upd_pol_e;

    // Grouped sync wins over the per-register bit.
    function automatic upd_pol_e pick_pol(input logic all_bit, input logic sep_bit);
        if (all_bit)      return POL_ALL;
        else if (sep_bit) return POL_SEP;
        else              return POL_IMM;
    endfunction

endpackage

// File: rtl/upd_en_edge.sv
module upd_en_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic breath_sel,
    output logic flic_en,
    output logic br_en,
    output logic flic_rise,
    output logic br_rise
);
    typedef struct packed {
        logic fl;
        logic br;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        flic_en   = en & ~breath_sel;
        br_en     = en & breath_sel;
        flic_rise = flic_en & ~st_q.fl;
        br_rise   = br_en & ~st_q.br;
        st_d.fl   = flic_en;
        st_d.br   = br_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/upd_commit_ctl.sv
module upd_commit_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_all,
    input  logic flic_en,
    input  logic br_en,
    input  logic prd_wr,
    input  logic brp_wr,
    input  logic period_end,
    input  logic breath_end,
    output logic pending,
    output logic commit_flic,
    output logic commit_br
);
    typedef struct packed {
        logic armed;
    } cmt_st_t;

    cmt_st_t st_d, st_q;

    always_comb begin
        logic arm;
        commit_flic = sync_all & flic_en & st_q.armed & period_end;
        commit_br   = sync_all & br_en & st_q.armed & breath_end;
        arm         = sync_all & ((flic_en & prd_wr) | (br_en & brp_wr));
        st_d        = st_q;
        if (!(flic_en | br_en)) begin
            st_d.armed = 1'b0;
        end else begin
            st_d.armed = (st_q.armed & ~(commit_flic | commit_br)) | arm;
        end
        pending = st_q.armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/upd_shadow_cell.sv
module upd_shadow_cell #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] active
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] active;
    } cell_st_t;

    cell_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr)   st_d.shadow = wr_data;
        if (load) st_d.active = st_d.shadow;
        active = st_q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_shadow_update.sv
module pwm_shadow_update
    import pwm_upd_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int DATA_W  = 24,
    parameter int PRD_W   = 16,
    parameter int CMP_W   = 16,
    parameter int ACT_W   = 12,
    parameter int PAUSE_W = 3,
    parameter int BR_W    = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH+4:0]            wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         sync_all,
    input  logic [NUM_CH+4:0]            sync_sep,
    input  logic                         en,
    input  logic                         breath_sel,
    input  logic                         period_end,
    input  logic                         breath_end,
    output logic [PRD_W-1:0]             act_prd,
    output logic [NUM_CH-1:0][CMP_W-1:0] act_cmp,
    output logic [ACT_W-1:0]             act_ctl,
    output logic [PAUSE_W-1:0]           act_pause,
    output logic [BR_W-1:0]              act_brp,
    output logic [BR_W-1:0]              act_hold
);
    localparam int NREG      = NUM_CH + 5;
    localparam int IDX_PRD   = 0;
    localparam int IDX_CMP0  = 1;
    localparam int IDX_CTL   = NUM_CH + 1;
    localparam int IDX_PAUSE = NUM_CH + 2;
    localparam int IDX_BRP   = NUM_CH + 3;
    localparam int IDX_HOLD  = NUM_CH + 4;

    logic flic_en, br_en, flic_rise, br_rise;
    logic pend, commit_flic, commit_br;
    logic [NREG-1:0] load;

    upd_en_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .breath_sel (breath_sel),
        .flic_en    (flic_en),
        .br_en      (br_en),
        .flic_rise  (flic_rise),
        .br_rise    (br_rise)
    );

    upd_commit_ctl u_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_all    (sync_all),
        .flic_en     (flic_en),
        .br_en       (br_en),
        .prd_wr      (wr_en[IDX_PRD]),
        .brp_wr      (wr_en[IDX_BRP]),
        .period_end  (period_end),
        .breath_end  (breath_end),
        .pending     (pend),
        .commit_flic (commit_flic),
        .commit_br   (commit_br)
    );

    // Per-register load strobe from policy, events and enable edges.
    always_comb begin
        load = '0;
        for (int i = 0; i < NREG; i++) begin
            logic     is_prd, is_fl, is_br, sep_evt, grp_commit, rise, base;
            upd_pol_e pol;
            is_prd     = (i == IDX_PRD);
            is_fl      = (i >= IDX_CMP0) && (i <= IDX_PAUSE);
            is_br      = (i == IDX_BRP) || (i == IDX_HOLD);
            pol        = pick_pol(sync_all, sync_sep[i]);
            sep_evt    = is_prd ? ((flic_en & period_end) | (br_en & breath_end))
                       : (is_br ? (br_en & breath_end) : (flic_en & period_end));
            grp_commit = (commit_flic & (is_prd | (is_fl & (i != IDX_PAUSE))))
                       | (commit_br & (is_prd | is_br));
            rise       = (flic_rise & (is_prd | is_fl)) | (br_rise & (is_prd | is_br));
            case (pol)
                POL_IMM: base = 1'b1;
                POL_SEP: base = sep_evt;
                default: base = grp_commit;
            endcase
            load[i] = base | rise;
        end
    end

    upd_shadow_cell #(.W(PRD_W)) u_prd (
        .clk(clk), .rst_n(rst_n), .wr(wr_en[IDX_PRD]), .wr_data(wr_data[PRD_W-1:0]),
        .load(load[IDX_PRD]), .active(act_prd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        upd_shadow_cell #(.W(CMP_W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .wr(wr_en[IDX_CMP0+c]), .wr_data(wr_data[CMP_W-1:0]),
            .load(load[IDX_CMP0+c]), .active(act_cmp[c])
        );
    end

    upd_shadow_cell #(.W(ACT_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(wr_en[IDX_CTL]), .wr_data(wr_data[ACT_W-1:0]),
        .load(load[IDX_CTL]), .active(act_ctl)
    );

    upd_shadow_cell #(.W(PAUSE_W)) u_pause (
        .clk(clk), .rst_n(rst_n), .wr(wr_en[IDX_PAUSE]), .wr_data(wr_data[PAUSE_W-1:0]),
        .load(load[IDX_PAUSE]), .active(act_pause)
    );

    upd_shadow_cell #(.W(BR_W)) u_brp (
        .clk(clk), .rst_n(rst_n), .wr(wr_en[IDX_BRP]), .wr_data(wr_data[BR_W-1:0]),
        .load(load[IDX_BRP]), .active(act_brp)
    );

    upd_shadow_cell #(.W(BR_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr(wr_en[IDX_HOLD]), .wr_data(wr_data[BR_W-1:0]),
        .load(load[IDX_HOLD]), .active(act_hold)
    );
endmodule

// File: rtl/pwm_shadow_update_chk.sv
module pwm_shadow_update_chk #(
    parameter int NUM_CH  = 3,
    parameter int DATA_W  = 24,
    parameter int PRD_W   = 16,
    parameter int CMP_W   = 16,
    parameter int PAUSE_W = 3,
    parameter int BR_W    = 24
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH+4:0]            wr_en,
    input logic [DATA_W-1:0]            wr_data,
    input logic                         sync_all,
    input logic [NUM_CH+4:0]            sync_sep,
    input logic                         en,
    input logic                         period_end,
    input logic                         breath_end,
    input logic [PRD_W-1:0]             act_prd,
    input logic [NUM_CH-1:0][CMP_W-1:0] act_cmp,
    input logic [PAUSE_W-1:0]           act_pause,
    input logic [BR_W-1:0]              act_brp,
    input logic                         pend,
    input logic                         flic_rise,
    input logic                         br_rise
);
    a_r3_imm_prd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_all && !sync_sep[0] && wr_en[0]) |=> (act_prd == $past(wr_data[PRD_W-1:0])));

    a_r4_sep_cmp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_all && sync_sep[1] && !period_end && !flic_rise) |=> $stable(act_cmp[0]));

    a_r8_all_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_all && !flic_rise) |=> $stable(act_pause));

    a_r7_all_brp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_all && !breath_end && !br_rise) |=> $stable(act_brp));

    a_r12_pend_clear_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> !pend);
endmodule

bind pwm_shadow_update pwm_shadow_update_chk #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .PRD_W(PRD_W), .CMP_W(CMP_W),
    .PAUSE_W(PAUSE_W), .BR_W(BR_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sync_all(sync_all), .sync_sep(sync_sep), .en(en),
    .period_end(period_end), .breath_end(breath_end),
    .act_prd(act_prd), .act_cmp(act_cmp), .act_pause(act_pause), .act_brp(act_brp),
    .pend(pend), .flic_rise(flic_rise), .br_rise(br_rise)
);

// File: tb/test_pwm_shadow_update.sv
`timescale 1ns/1ps
module test_pwm_shadow_update;
    localparam int NCH = 3;
    localparam int NR  = NCH + 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0] wr_en = '0;
    logic [23:0] wr_data = '0;
    logic sync_all = 1'b0;
    logic [NR-1:0] sync_sep = '0;
    logic en = 1'b0, breath_sel = 1'b0, period_end = 1'b0, breath_end = 1'b0;
    logic [15:0] act_prd;
    logic [NCH-1:0][15:0] act_cmp;
    logic [11:0] act_ctl;
    logic [2:0] act_pause;
    logic [23:0] act_brp, act_hold;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    logic [23:0] m_sh [NR];
    logic [23:0] m_act [NR];
    logic m_pend, m_fq, m_bq;

    always #10 clk = ~clk;

    pwm_shadow_update i_pwm_shadow_update (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .sync_all(sync_all), .sync_sep(sync_sep), .en(en), .breath_sel(breath_sel),
        .period_end(period_end), .breath_end(breath_end),
        .act_prd(act_prd), .act_cmp(act_cmp), .act_ctl(act_ctl), .act_pause(act_pause),
        .act_brp(act_brp), .act_hold(act_hold)
    );

    function automatic logic [23:0] wmask(input int i);
        if (i <= NCH)        return 24'h00FFFF;
        else if (i == NCH+1) return 24'h000FFF;
        else if (i == NCH+2) return 24'h000007;
        else                 return 24'hFFFFFF;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        m_pend = 1'b0; m_fq = 1'b0; m_bq = 1'b0;
    endtask

    // Reference behaviour written from the requirements
    task automatic model_step();
        logic fl, br, fr, brr, cf, cb, ld, is_fl_grp, is_br_grp;
        fl  = en & ~breath_sel;
        br  = en & breath_sel;
        fr  = fl & ~m_fq;
        brr = br & ~m_bq;
        cf  = sync_all & fl & m_pend & period_end;
        cb  = sync_all & br & m_pend & breath_end;
        for (int i = 0; i < NR; i++) begin
            if (wr_en[i]) m_sh[i] = wr_data & wmask(i);
            is_fl_grp = (i >= 1 && i <= NCH+2);
            is_br_grp = (i >= NCH+3);
            if (sync_all) begin
                if (i == 0)                     ld = cf | cb;
                else if (i <= NCH+1)            ld = cf;
                else if (i == NCH+2)            ld = 1'b0;
                else                            ld = cb;
            end else if (sync_sep[i]) begin
                if (i == 0)          ld = (fl & period_end) | (br & breath_end);
                else if (is_br_grp)  ld = br & breath_end;
                else                 ld = fl & period_end;
            end else begin
                ld = 1'b1;
            end
            if (fr && (i == 0 || is_fl_grp)) ld = 1'b1;
            if (brr && (i == 0 || is_br_grp)) ld = 1'b1;
            if (ld) m_act[i] = m_sh[i];
        end
        if (!en) m_pend = 1'b0;
        else m_pend = (m_pend & ~(cf | cb)) |
                      (sync_all & ((fl & wr_en[0]) | (br & wr_en[NCH+3])));
        m_fq = fl;
        m_bq = br;
    endtask

    task automatic compare(input string tag);
        logic [23:0] got [NR];
        bit bad = 1'b0;
        got[0] = {8'h0, act_prd};
        for (int c = 0; c < NCH; c++) got[1+c] = {8'h0, act_cmp[c]};
        got[NCH+1] = {12'h0, act_ctl};
        got[NCH+2] = {21'h0, act_pause};
        got[NCH+3] = act_brp;
        got[NCH+4] = act_hold;
        n_cmp++;
        for (int i = 0; i < NR; i++) begin
            if (got[i] !== m_act[i]) begin
                if (!bad) n_bad++;
                bad = 1'b1;
                $display("FAIL %s reg%0d actual=%h expected=%h", tag, i, got[i], m_act[i]);
            end
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
        wr_en = '0; period_end = 1'b0; breath_end = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [23:0] d);
        wr_en = '0; wr_en[idx] = 1'b1; wr_data = d;
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        step("R1");

        // R3: immediate policy while disabled
        wr(1, 24'h001234); step("R3");
        wr(0, 24'h00A5A5); step("R3");

        // R4 / R9: per-register sync, flicker
        sync_sep = '1;
        wr(2, 24'h000055); step("R4");
        en = 1'b1; step("R9");
        wr(3, 24'h000777); step("R4");
        step("R4");
        period_end = 1'b1; step("R4");
        wr(0, 24'h000321); step("R5");
        period_end = 1'b1; step("R5");
        wr(NCH+2, 24'h000005); breath_end = 1'b1; step("R4");

        // R10 / R4 / R5: breath side
        wr(NCH+3, 24'h123456); step("R4");
        breath_sel = 1'b1; step("R10");
        wr(NCH+4, 24'h0ABCDE); step("R4");
        period_end = 1'b1; step("R4");
        breath_end = 1'b1; step("R4");
        wr(0, 24'h004444); period_end = 1'b1; step("R5");
        breath_end = 1'b1; step("R5");

        // R6 / R11 / R8: sync-all flicker, per-register bits still set
        sync_all = 1'b1;
        en = 1'b0; step("R9");
        breath_sel = 1'b0; en = 1'b1; step("R9");
        wr(1, 24'h00BEEF); step("R11");
        period_end = 1'b1; step("R6");
        wr(0, 24'h000100); step("R6");
        wr(NCH+1, 24'h000ABC); step("R6");
        period_end = 1'b1; step("R6");
        wr(NCH+2, 24'h000003); step("R8");
        period_end = 1'b1; step("R8");

        // R12: arm dropped by disable, and by the commit itself
        wr(0, 24'h000200); step("R12");
        en = 1'b0; step("R12");
        en = 1'b1; step("R9");
        wr(2, 24'h001111); step("R12");
        period_end = 1'b1; step("R12");
        wr(0, 24'h000300); step("R12");
        period_end = 1'b1; step("R6");
        wr(3, 24'h002222); step("R12");
        period_end = 1'b1; step("R12");

        // R7: sync-all breath
        breath_sel = 1'b1; step("R10");
        wr(NCH+4, 24'h00FFFF); step("R7");
        breath_end = 1'b1; step("R7");
        wr(NCH+3, 24'h0F0F0F); step("R7");
        wr(0, 24'h000999); step("R7");
        breath_end = 1'b1; step("R7");
        breath_end = 1'b1; step("R7");

        // Random mix across all policies (R2)
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            wr_en = '0;
            if (r < 35) wr_en[$urandom_range(0, NR-1)] = 1'b1;
            wr_data = 24'($urandom);
            if ($urandom_range(0, 49) == 0) sync_all = ~sync_all;
            if ($urandom_range(0, 49) == 0) sync_sep = NR'($urandom);
            if ($urandom_range(0, 29) == 0) en = ~en;
            if ($urandom_range(0, 39) == 0) breath_sel = ~breath_sel;
            period_end = ($urandom_range(0, 7) == 0);
            breath_end = ($urandom_range(0, 9) == 0);
            step("R2");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule